// File: doc/BRIEF.md
# Shadow-Register Backup/Restore Sequencer

This block models a bank of non-volatile flip-flops for a core that is switched fully off between bursts of work. Every working flip-flop has a shadow storage bit beside it. A sequencer copies the working state into the shadow bits before power is removed. When power returns, it copies that state back, and only then lets the core run again. During normal execution the core only reads and writes the working flip-flops.

Writing a shadow bit takes several clock cycles, and writing every bit at once would draw too much current. The backup therefore walks through the bank one group of bits at a time, holding each group's write control for the full write latency. A restore is much shorter and has two phases. A restore-enable phase senses the shadow values. A restore-load phase then routes them into the working flip-flops through the input mux of each bit. The working flip-flops read zero while power is off, which models the loss of volatile state. The core stays stalled from the backup request until the restore has finished.

Top module: `shadow_backup_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, `stall_o`, `backup_done_o` and `restore_done_o` are 0 and `q_o` is all zeros.
- R2: In run mode (`stall_o` low), `q_o` takes `d_i` at the clock edge where `we_i` is high, and holds its value at an edge where `we_i` is low.
- R3: `pdn_req_i` high at an edge in run mode starts a backup. From the next cycle, `stall_o` stays high up to the last restore-load cycle, and `q_o` ignores `we_i` and `d_i` throughout. `stall_o` is low in the cycle where `restore_done_o` is high, unless a deferred request exists (R8).
- R4: The backup writes groups of `GROUP_BITS` bits, lowest indices first, and never writes more than `GROUP_BITS` shadow bits at once. Each group's write control is held for `WR_CYCLES` consecutive cycles. `backup_done_o` is a one-cycle pulse, high in the cycle that begins `ceil(NUM_BITS/GROUP_BITS)*WR_CYCLES` edges after the edge that sampled the request.
- R5: After the backup completes and until a restore loads, the block is powered down. In this state `q_o` reads all zeros, and `we_i` and `pdn_req_i` have no effect.
- R6: `pup_req_i` high at an edge while powered down starts a restore. The restore runs `REN_CYCLES` cycles of restore-enable and then `RLD_CYCLES` cycles of restore-load, with neither phase overlapping a shadow write. `restore_done_o` is a one-cycle pulse, high in the cycle that begins `REN_CYCLES+RLD_CYCLES` edges after the request edge. In that cycle `q_o` equals the value it held when the backup was requested.
- R7: `pup_req_i` outside the powered-down state has no effect: in run mode `stall_o` stays low and `q_o` is unchanged.
- R8: `pdn_req_i` during a restore is deferred. `stall_o` stays high in the `restore_done_o` cycle, and a new backup starts at once, so `backup_done_o` follows `ceil(NUM_BITS/GROUP_BITS)*WR_CYCLES` edges after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| d_i | input | NUM_BITS | Next-state data from the core |
| we_i | input | 1 | Core update enable for the working flip-flops |
| pdn_req_i | input | 1 | Power-down request (backup) |
| pup_req_i | input | 1 | Power-up request (restore) |
| q_o | output | NUM_BITS | Working flip-flop state |
| stall_o | output | 1 | Holds the core while backup, power-down or restore is in progress |
| backup_done_o | output | 1 | One-cycle pulse when every group has been written |
| restore_done_o | output | 1 | One-cycle pulse when the working state has been reloaded |

## Verification
The assertions assume that the request inputs are synchronous to `clk_i` and are sampled only at rising edges. They also assume that the core respects `stall_o`, so any `we_i` activity while stalled is just noise that must be discarded. The stimulus drives every input at the falling edge and gives each request as a single-cycle pulse. It deliberately toggles `we_i` and `d_i` during backup and power-down, to show that such activity is dropped. Power-down and power-up requests are issued in the states where R5, R7 and R8 say they must be ignored or deferred.

// File: rtl/shadow_seq_pkg.sv
package shadow_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN = 3'd0,
    ST_BKP = 3'd1,
    ST_OFF = 3'd2,
    ST_REN = 3'd3,
    ST_RLD = 3'd4
  } seq_state_e;
endpackage

// File: rtl/nv_bit_cell.sv
module nv_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic upd_i,
  input  logic clr_i,
  input  logic sw_i,
  input  logic commit_i,
  input  logic ren_i,
  input  logic rld_i,
  output logic q_o
);
  logic work_q, shadow_q, sense_q;
  logic next_d;

  // input mux: core data or sensed shadow value
  assign next_d = rld_i ? sense_q : d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q   <= 1'b0;
      shadow_q <= 1'b0;
      sense_q  <= 1'b0;
    end else begin
      if (clr_i)              work_q <= 1'b0;
      else if (rld_i || upd_i) work_q <= next_d;
      if (sw_i && commit_i)   shadow_q <= work_q;
      if (ren_i)              sense_q <= shadow_q;
    end
  end

  assign q_o = work_q;
endmodule

// File: rtl/nv_cell_array.sv
module nv_cell_array #(
  parameter int NUM_BITS   = 16,
  parameter int GROUP_BITS = 5,
  parameter int GW         = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_BITS-1:0] d_i,
  input  logic                upd_i,
  input  logic                clr_i,
  input  logic                wr_active_i,
  input  logic [GW-1:0]       grp_i,
  input  logic                commit_i,
  input  logic                ren_i,
  input  logic                rld_i,
  output logic [NUM_BITS-1:0] q_o,
  output logic [NUM_BITS-1:0] sw_o
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    localparam int GI = i / GROUP_BITS;
    assign sw_o[i] = wr_active_i && (grp_i == GW'(GI));
    nv_bit_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .d_i      (d_i[i]),
      .upd_i    (upd_i),
      .clr_i    (clr_i),
      .sw_i     (sw_o[i]),
      .commit_i (commit_i),
      .ren_i    (ren_i),
      .rld_i    (rld_i),
      .q_o      (q_o[i])
    );
  end

  // R4
  grp_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sw_o) <= GROUP_BITS);

  // R5
  off_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0));
endmodule

// File: rtl/backup_restore_fsm.sv
module backup_restore_fsm
  import shadow_seq_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int WR_CYCLES  = 4,
  parameter int REN_CYCLES = 2,
  parameter int RLD_CYCLES = 1,
  parameter int GW         = 2,
  parameter int TW         = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pdn_req_i,
  input  logic          pup_req_i,
  output logic          stall_o,
  output logic          wr_active_o,
  output logic [GW-1:0] grp_o,
  output logic          commit_o,
  output logic          ren_o,
  output logic          rld_o,
  output logic          clr_o,
  output logic          backup_done_o,
  output logic          restore_done_o
);
  seq_state_e    state_q, state_d;
  logic [GW-1:0] grp_q, grp_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          pend_q, pend_d;
  logic          bdone_q, bdone_d, rdone_q, rdone_d;
  logic          wr_last, ren_last, rld_last, grp_last, pend_now;

  assign wr_last  = (tmr_q == TW'(WR_CYCLES - 1));
  assign ren_last = (tmr_q == TW'(REN_CYCLES - 1));
  assign rld_last = (tmr_q == TW'(RLD_CYCLES - 1));
  assign grp_last = (grp_q == GW'(NUM_GROUPS - 1));
  assign pend_now = pend_q || pdn_req_i;

  always_comb begin
    state_d = state_q;
    grp_d   = grp_q;
    tmr_d   = tmr_q;
    pend_d  = pend_q;
    bdone_d = 1'b0;
    rdone_d = 1'b0;
    unique case (state_q)
      ST_RUN: if (pend_now) begin
        state_d = ST_BKP;
        grp_d   = '0;
        tmr_d   = '0;
        pend_d  = 1'b0;
      end
      ST_BKP: if (wr_last) begin
        tmr_d = '0;
        if (grp_last) begin
          state_d = ST_OFF;
          bdone_d = 1'b1;
        end else begin
          grp_d = grp_q + GW'(1);
        end
      end else begin
        tmr_d = tmr_q + TW'(1);
      end
      ST_OFF: if (pup_req_i) begin
        state_d = ST_REN;
        tmr_d   = '0;
      end
      ST_REN: begin
        pend_d = pend_now;
        if (ren_last) begin
          state_d = ST_RLD;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      ST_RLD: if (rld_last) begin
        rdone_d = 1'b1;
        tmr_d   = '0;
        grp_d   = '0;
        pend_d  = 1'b0;
        state_d = pend_now ? ST_BKP : ST_RUN;
      end else begin
        tmr_d  = tmr_q + TW'(1);
        pend_d = pend_now;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      grp_q   <= '0;
      tmr_q   <= '0;
      pend_q  <= 1'b0;
      bdone_q <= 1'b0;
      rdone_q <= 1'b0;
    end else begin
      state_q <= state_d;
      grp_q   <= grp_d;
      tmr_q   <= tmr_d;
      pend_q  <= pend_d;
      bdone_q <= bdone_d;
      rdone_q <= rdone_d;
    end
  end

  assign stall_o        = (state_q != ST_RUN);
  assign wr_active_o    = (state_q == ST_BKP);
  assign grp_o          = grp_q;
  assign commit_o       = wr_active_o && wr_last;
  assign ren_o          = (state_q == ST_REN);
  assign rld_o          = (state_q == ST_RLD);
  assign clr_o          = (state_q == ST_OFF);
  assign backup_done_o  = bdone_q;
  assign restore_done_o = rdone_q;

  // R6
  load_after_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rld_o) |-> $past(ren_o));

  // R6
  done_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_done_o |-> $past(rld_o));
endmodule

// File: rtl/shadow_backup_seq.sv
module shadow_backup_seq #(
  parameter int NUM_BITS   = 16,
  parameter int GROUP_BITS = 5,
  parameter int WR_CYCLES  = 4,
  parameter int REN_CYCLES = 2,
  parameter int RLD_CYCLES = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_BITS-1:0] d_i,
  input  logic                we_i,
  input  logic                pdn_req_i,
  input  logic                pup_req_i,
  output logic [NUM_BITS-1:0] q_o,
  output logic                stall_o,
  output logic                backup_done_o,
  output logic                restore_done_o
);
  localparam int NUM_GROUPS = (NUM_BITS + GROUP_BITS - 1) / GROUP_BITS;
  localparam int GW   = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int MAXC = (WR_CYCLES > REN_CYCLES)
                      ? ((WR_CYCLES > RLD_CYCLES) ? WR_CYCLES : RLD_CYCLES)
                      : ((REN_CYCLES > RLD_CYCLES) ? REN_CYCLES : RLD_CYCLES);
  localparam int TW   = (MAXC > 1) ? $clog2(MAXC + 1) : 1;
  localparam int HW   = $clog2(WR_CYCLES + 2);

  logic          wr_active, commit, ren, rld, clr, upd;
  logic [GW-1:0] grp;
  logic [NUM_BITS-1:0] sw;

  assign upd = we_i && !stall_o;

  backup_restore_fsm #(
    .NUM_GROUPS (NUM_GROUPS),
    .WR_CYCLES  (WR_CYCLES),
    .REN_CYCLES (REN_CYCLES),
    .RLD_CYCLES (RLD_CYCLES),
    .GW         (GW),
    .TW         (TW)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pdn_req_i      (pdn_req_i),
    .pup_req_i      (pup_req_i),
    .stall_o        (stall_o),
    .wr_active_o    (wr_active),
    .grp_o          (grp),
    .commit_o       (commit),
    .ren_o          (ren),
    .rld_o          (rld),
    .clr_o          (clr),
    .backup_done_o  (backup_done_o),
    .restore_done_o (restore_done_o)
  );

  nv_cell_array #(
    .NUM_BITS   (NUM_BITS),
    .GROUP_BITS (GROUP_BITS),
    .GW         (GW)
  ) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .d_i         (d_i),
    .upd_i       (upd),
    .clr_i       (clr),
    .wr_active_i (wr_active),
    .grp_i       (grp),
    .commit_i    (commit),
    .ren_i       (ren),
    .rld_i       (rld),
    .q_o         (q_o),
    .sw_o        (sw)
  );

  // checker: length of the current run of an unchanged, non-empty write vector
  logic [NUM_BITS-1:0] sw_prev_q;
  logic [HW-1:0]       run_q, run_cur;
  assign run_cur = (|sw) ? ((sw == sw_prev_q) ? run_q + HW'(1) : HW'(1)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_prev_q <= '0;
      run_q     <= '0;
    end else begin
      sw_prev_q <= sw;
      run_q     <= run_cur;
    end
  end

  // R4
  write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> (run_cur == HW'(WR_CYCLES)));

  // R6
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren || rld) |-> (sw == '0));

  // R3
  frozen_backup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_active |=> $stable(q_o));

  // R4
  done_stalled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backup_done_o |-> stall_o);
endmodule

// File: tb/tb_shadow_backup_seq.sv
module tb_shadow_backup_seq;
  localparam int N   = 16;
  localparam int G   = 5;
  localparam int WR  = 4;
  localparam int REN = 2;
  localparam int RLD = 1;
  localparam int NG  = (N + G - 1) / G;
  localparam int BKP_LAT = NG * WR;
  localparam int RST_LAT = REN + RLD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] d = '0;
  logic we = 1'b0, pdn = 1'b0, pup = 1'b0;
  logic [N-1:0] q;
  logic stall, bdone, rdone;

  int checks = 0, failures = 0;
  logic [N-1:0] exp_q[$];
  logic rdone_prev = 1'b0;

  always #10 clk = ~clk;

  shadow_backup_seq #(.NUM_BITS(N), .GROUP_BITS(G), .WR_CYCLES(WR),
                      .REN_CYCLES(REN), .RLD_CYCLES(RLD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .d_i(d), .we_i(we), .pdn_req_i(pdn),
    .pup_req_i(pup), .q_o(q), .stall_o(stall), .backup_done_o(bdone),
    .restore_done_o(rdone));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: restored state against scoreboard (R6)
  always @(negedge clk) begin
    if (rst_n) begin
      if (rdone) begin
        if (exp_q.size() == 0) chk("R6 unexpected restore_done", 32'd1, 32'd0);
        else chk("R6 restored q_o", 32'(q), 32'(exp_q.pop_front()));
        chk("R6 restore_done one cycle", 32'(rdone_prev), 32'd0);
      end
      rdone_prev <= rdone;
    end
  end

  task automatic load(input logic [N-1:0] v);
    we = 1'b1; d = v;
    @(negedge clk);
    we = 1'b0;
    chk("R2 load", 32'(q), 32'(v));
  endtask

  // backup with noise on we_i/d_i; returns after backup_done seen
  task automatic do_backup(input logic [N-1:0] v);
    int n;
    bit stall_ok;
    exp_q.push_back(v);
    pdn = 1'b1;
    @(negedge clk);
    pdn = 1'b0; we = 1'b1; d = ~v;
    n = 1; stall_ok = 1'b1;
    while (!bdone && n < 500) begin
      if (!stall) stall_ok = 1'b0;
      @(negedge clk); n++;
    end
    chk("R4 backup latency", 32'(n), 32'(1 + BKP_LAT));
    chk("R3 stall during backup", 32'(stall_ok), 32'd1);
    chk("R3 q frozen during backup", 32'(q), 32'(v));
    @(negedge clk);
    chk("R4 backup_done one cycle", 32'(bdone), 32'd0);
    chk("R5 q zero while off", 32'(q), 32'd0);
    we = 1'b0;
  endtask

  task automatic do_restore();
    int n;
    pup = 1'b1;
    @(negedge clk);
    pup = 1'b0; n = 1;
    while (!rdone && n < 500) begin
      @(negedge clk); n++;
    end
    chk("R6 restore latency", 32'(n), 32'(1 + RST_LAT));
    chk("R3 stall low at restore_done", 32'(stall), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] pats [4];
    pats[0] = 16'h1234; pats[1] = 16'hFFFF; pats[2] = 16'h0001; pats[3] = 16'h8000;

    repeat (2) @(negedge clk);
    // R1
    chk("R1 stall in reset", 32'(stall), 32'd0);
    chk("R1 q in reset", 32'(q), 32'd0);
    chk("R1 dones in reset", 32'({bdone, rdone}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 32'({stall, bdone, rdone, |q}), 32'd0);

    // R2
    load(16'hA5A5);
    d = 16'hFFFF; we = 1'b0;
    @(negedge clk);
    chk("R2 hold with we low", 32'(q), 32'hA5A5);

    // R7: power-up request in run mode
    pup = 1'b1;
    @(negedge clk);
    pup = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R7 no stall", 32'(stall), 32'd0);
      @(negedge clk);
    end
    chk("R7 q unchanged", 32'(q), 32'hA5A5);

    // R4 R5 R6: several power cycles
    for (int k = 0; k < 4; k++) begin
      load(pats[k]);
      do_backup(pats[k]);
      // R5: power-down request and updates ignored while off
      pdn = 1'b1; we = 1'b1; d = 16'h5A5A;
      @(negedge clk);
      pdn = 1'b0; we = 1'b0;
      for (int i = 0; i < 3; i++) begin
        chk("R5 no second backup_done", 32'(bdone), 32'd0);
        chk("R5 q zero", 32'(q), 32'd0);
        @(negedge clk);
      end
      do_restore();
      @(negedge clk);
    end

    // R8: deferred power-down during restore
    load(16'h3C3C);
    do_backup(16'h3C3C);
    begin
      int n, m;
      bit stall_ok;
      pup = 1'b1;
      @(negedge clk);
      pup = 1'b0;
      pdn = 1'b1;
      @(negedge clk);
      pdn = 1'b0; n = 2;
      while (!rdone && n < 500) begin
        @(negedge clk); n++;
      end
      chk("R8 restore latency", 32'(n), 32'(1 + RST_LAT));
      chk("R8 stall held at restore_done", 32'(stall), 32'd1);
      m = 0; stall_ok = 1'b1;
      while (!bdone && m < 500) begin
        @(negedge clk); m++;
        if (!stall) stall_ok = 1'b0;
      end
      chk("R8 deferred backup latency", 32'(m), 32'(BKP_LAT));
      chk("R8 stall continuous", 32'(stall_ok), 32'd1);
    end
    exp_q.push_back(16'h3C3C);
    @(negedge clk);
    do_restore();
    @(negedge clk);
    load(16'h0F0F);
    chk("R2 run after restore", 32'(stall), 32'd0);
    chk("R6 scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule